// File: doc/BRIEF.md
# Selective Refresh Controller for a Short-Retention Cache

This block watches the age of every line in a set-associative cache whose storage cells hold data only for a limited time. A coarse retention tick ages all lines. A demand write to a line restores its full retention. A scanner visits one line per clock cycle in round-robin order. When the line under the scanner is close to losing its data, the block chooses one of three actions. A line in the recently used half of its set is copied into a small refresh buffer and later written back into the array, which renews it. A line in the other half, or a line that finds the buffer full, is written back to main memory if it is dirty, or invalidated if it is clean.

The refresh buffer is drained by a copy-back engine. Each copy-back holds the array for a fixed number of cycles, the same as a demand write. Demand writes always win: a copy-back waits until the array is idle and no demand write is offered in that cycle. While a line waits in the buffer, it keeps ageing. Recency positions come from the replacement logic outside this block, one way at a time.

Top module: `rsr_ctrl`

## Requirements
- R1: During and directly after reset, all lines are invalid, no action or copy-back is requested, the buffer reports empty and not full, and the recency position of each way equals its way number.
- R2: On each retention tick, every line's age goes up by one and saturates at the counter maximum. A demand write sets the written line's age to zero, marks it valid and loads its dirty bit from the write.
- R3: The scanner visits line index set*WAYS+way, starting at 0 after reset, moving up by one per cycle and wrapping after the last line. It acts only on a line that is valid, not queued for refresh, and whose age is at least EXPIRE_AGE. At most one of copy-out, write-back and invalidate is asserted per cycle, and each comes with that line's set and way.
- R4: An expiring line whose recency position is below WAYS/2 (important) asserts copy-out when the buffer is not full. Its index is appended to the buffer and the line is marked queued.
- R5: An expiring line whose recency position is WAYS/2 or above asserts write-back if dirty and invalidate if clean. In both cases the line becomes invalid.
- R6: An expiring important line that finds the buffer full is handled as in R5.
- R7: A copy-back starts (one-cycle pulse carrying the buffer head's set and way) when the buffer is non-empty, no copy-back is running, the array is idle and no demand write is offered. Entries leave in arrival order. The copy-back lasts WRITE_CYC cycles. At its end the entry is freed, and the line's age becomes zero and its queued mark is cleared.
- R8: A demand write keeps the array busy for WRITE_CYC cycles and blocks a copy-back start in its own cycle. A queued line keeps ageing on ticks until its copy-back completes.
- R9: The buffer-full flag is high exactly when BUF_DEPTH entries are held, and the empty flag exactly when none are, both updated at the edge of the push or pop.
- R10: A demand write to the line under the scanner in the same cycle suppresses any action on that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Retention tick, ages all lines |
| dwr_valid_i | input | 1 | Demand write this cycle |
| dwr_set_i | input | SET_W | Set of the demand write |
| dwr_way_i | input | WAY_W | Way of the demand write |
| dwr_dirty_i | input | 1 | Dirty bit of the written line |
| pos_valid_i | input | 1 | Recency position update |
| pos_set_i | input | SET_W | Set of the update |
| pos_way_i | input | WAY_W | Way of the update |
| pos_rank_i | input | WAY_W | New recency position, 0 = most recent |
| copy_out_o | output | 1 | Copy line into refresh buffer |
| wb_req_o | output | 1 | Write line back to main memory |
| inv_o | output | 1 | Invalidate line |
| act_set_o | output | SET_W | Set of the line under the scanner |
| act_way_o | output | WAY_W | Way of the line under the scanner |
| copy_back_o | output | 1 | Start of a copy-back into the array |
| cb_set_o | output | SET_W | Set of the copy-back line |
| cb_way_o | output | WAY_W | Way of the copy-back line |
| buf_full_o | output | 1 | Refresh buffer full |
| buf_empty_o | output | 1 | Refresh buffer empty |

## Verification
The first directed pattern writes every line once and then lets ticks run with no further writes. All lines then expire together, which fills the buffer and forces the full-buffer fallback, separating R4 from R6. A randomly mixed pattern of demand writes, recency updates and regular ticks separates recent from old lines and dirty from clean ones. It also makes demand writes contend with copy-backs for the array. Within that pattern, demand writes are steered at the line under the scanner just as it would expire, which shows whether the same-cycle suppression of R10 is honoured.

// File: rtl/rsr_pkg.sv
package rsr_pkg;

    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_COPY  = 2'd1,
        ACT_WBACK = 2'd2,
        ACT_DROP  = 2'd3
    } act_e;

endpackage

// File: rtl/rsr_scanner.sv
module rsr_scanner #(
    parameter int LINES = 64,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [IDX_W-1:0] ptr_o
);
    logic [IDX_W-1:0] ptr_d, ptr_q;

    always_comb begin
        if (ptr_q == IDX_W'(LINES - 1)) ptr_d = '0;
        else                            ptr_d = ptr_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr_o = ptr_q;

    // R3
    scan_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (ptr_o == (($past(ptr_o) == IDX_W'(LINES - 1)) ? '0 : $past(ptr_o) + 1'b1)));

endmodule

// File: rtl/rsr_refresh_fifo.sv
module rsr_refresh_fifo #(
    parameter int DEPTH = 4,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [IDX_W-1:0] push_idx_i,
    input  logic             pop_i,
    output logic [IDX_W-1:0] head_o,
    output logic             full_o,
    output logic             empty_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][IDX_W-1:0] slot;
        logic [PTR_W-1:0]            rd;
        logic [PTR_W-1:0]            wr;
        logic [CNT_W-1:0]            cnt;
    } fifo_t;

    fifo_t f_d, f_q;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        f_d = f_q;
        if (push_i) begin
            f_d.slot[f_q.wr] = push_idx_i;
            f_d.wr           = bump(f_q.wr);
        end
        if (pop_i) f_d.rd = bump(f_q.rd);
        case ({push_i, pop_i})
            2'b10:   f_d.cnt = f_q.cnt + 1'b1;
            2'b01:   f_d.cnt = f_q.cnt - 1'b1;
            default: f_d.cnt = f_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign head_o  = f_q.slot[f_q.rd];
    assign full_o  = (f_q.cnt == CNT_W'(DEPTH));
    assign empty_o = (f_q.cnt == '0);

    // R9
    fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.cnt <= CNT_W'(DEPTH));
    // R9
    full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(full_o && empty_o));
    // R6
    no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> !full_o);
    // R7
    no_pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> !empty_o);

endmodule

// File: rtl/rsr_line_table.sv
module rsr_line_table #(
    parameter int LINES = 64,
    parameter int WAY_W = 4,
    parameter int AGE_W = 4,
    parameter int IDX_W = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          tick_i,
    input  logic                          wr_i,
    input  logic [IDX_W-1:0]              wr_idx_i,
    input  logic                          wr_dirty_i,
    input  logic                          pos_i,
    input  logic [IDX_W-1:0]              pos_idx_i,
    input  logic [WAY_W-1:0]              pos_rank_i,
    input  logic                          kill_i,
    input  logic [IDX_W-1:0]              kill_idx_i,
    input  logic                          queue_i,
    input  logic [IDX_W-1:0]              queue_idx_i,
    input  logic                          done_i,
    input  logic [IDX_W-1:0]              done_idx_i,
    output logic [LINES-1:0]              valid_o,
    output logic [LINES-1:0]              dirty_o,
    output logic [LINES-1:0]              pend_o,
    output logic [LINES-1:0][AGE_W-1:0]   age_o,
    output logic [LINES-1:0][WAY_W-1:0]   rank_o
);
    typedef struct packed {
        logic [LINES-1:0]            valid;
        logic [LINES-1:0]            dirty;
        logic [LINES-1:0]            pend;
        logic [LINES-1:0][AGE_W-1:0] age;
        logic [LINES-1:0][WAY_W-1:0] rank;
    } tbl_t;

    tbl_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        for (int i = 0; i < LINES; i++) begin
            if (tick_i && (t_q.age[i] != '1))
                t_d.age[i] = t_q.age[i] + 1'b1;
            if (wr_i && (wr_idx_i == IDX_W'(i))) begin
                t_d.age[i]   = '0;
                t_d.valid[i] = 1'b1;
                t_d.dirty[i] = wr_dirty_i;
            end
            if (done_i && (done_idx_i == IDX_W'(i))) begin
                t_d.age[i]  = '0;
                t_d.pend[i] = 1'b0;
            end
            if (kill_i && (kill_idx_i == IDX_W'(i)))
                t_d.valid[i] = 1'b0;
            if (queue_i && (queue_idx_i == IDX_W'(i)))
                t_d.pend[i] = 1'b1;
            if (pos_i && (pos_idx_i == IDX_W'(i)))
                t_d.rank[i] = pos_rank_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q.valid <= '0;
            t_q.dirty <= '0;
            t_q.pend  <= '0;
            t_q.age   <= '0;
            for (int i = 0; i < LINES; i++)
                t_q.rank[i] <= WAY_W'(i % (2 ** WAY_W));
        end else begin
            t_q <= t_d;
        end
    end

    assign valid_o = t_q.valid;
    assign dirty_o = t_q.dirty;
    assign pend_o  = t_q.pend;
    assign age_o   = t_q.age;
    assign rank_o  = t_q.rank;

    // R2
    wr_age_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (age_o[$past(wr_idx_i)] == '0) && valid_o[$past(wr_idx_i)]);
    // R7
    done_unqueue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> !pend_o[$past(done_idx_i)]);

endmodule

// File: rtl/rsr_ctrl.sv
module rsr_ctrl
    import rsr_pkg::*;
#(
    parameter int SETS       = 4,
    parameter int WAYS       = 16,
    parameter int AGE_W      = 4,
    parameter int EXPIRE_AGE = 12,
    parameter int BUF_DEPTH  = 4,
    parameter int WRITE_CYC  = 6,
    localparam int SET_W     = $clog2(SETS),
    localparam int WAY_W     = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             dwr_valid_i,
    input  logic [SET_W-1:0] dwr_set_i,
    input  logic [WAY_W-1:0] dwr_way_i,
    input  logic             dwr_dirty_i,
    input  logic             pos_valid_i,
    input  logic [SET_W-1:0] pos_set_i,
    input  logic [WAY_W-1:0] pos_way_i,
    input  logic [WAY_W-1:0] pos_rank_i,
    output logic             copy_out_o,
    output logic             wb_req_o,
    output logic             inv_o,
    output logic [SET_W-1:0] act_set_o,
    output logic [WAY_W-1:0] act_way_o,
    output logic             copy_back_o,
    output logic [SET_W-1:0] cb_set_o,
    output logic [WAY_W-1:0] cb_way_o,
    output logic             buf_full_o,
    output logic             buf_empty_o
);
    localparam int LINES = SETS * WAYS;
    localparam int IDX_W = SET_W + WAY_W;
    localparam int CNT_W = $clog2(WRITE_CYC + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cb_left;
        logic [CNT_W-1:0] arr_busy;
    } ctl_t;

    ctl_t c_d, c_q;

    logic [IDX_W-1:0]            scan_idx, head_idx, dwr_idx, pos_idx;
    logic [LINES-1:0]            line_valid, line_dirty, line_pend;
    logic [LINES-1:0][AGE_W-1:0] line_age;
    logic [LINES-1:0][WAY_W-1:0] line_rank;
    logic                        fifo_full, fifo_empty;
    logic                        due, important, cb_done;
    act_e                        act;

    assign dwr_idx = {dwr_set_i, dwr_way_i};
    assign pos_idx = {pos_set_i, pos_way_i};

    rsr_scanner #(.LINES(LINES), .IDX_W(IDX_W)) u_scan (
        .clk   (clk),
        .rst_n (rst_n),
        .ptr_o (scan_idx)
    );

    // Expiry decision for the line under the scanner
    always_comb begin
        due = line_valid[scan_idx] && !line_pend[scan_idx]
              && (line_age[scan_idx] >= AGE_W'(EXPIRE_AGE))
              && !(dwr_valid_i && (dwr_idx == scan_idx));
        important = (line_rank[scan_idx] < WAY_W'(WAYS / 2));
        if (!due)                         act = ACT_NONE;
        else if (important && !fifo_full) act = ACT_COPY;
        else if (line_dirty[scan_idx])    act = ACT_WBACK;
        else                              act = ACT_DROP;
    end

    // Copy-back engine and array occupancy
    always_comb begin
        c_d         = c_q;
        copy_back_o = !fifo_empty && (c_q.cb_left == '0)
                      && (c_q.arr_busy == '0) && !dwr_valid_i;
        cb_done     = (c_q.cb_left == CNT_W'(1));
        if (copy_back_o)          c_d.cb_left = CNT_W'(WRITE_CYC - 1);
        else if (c_q.cb_left != '0) c_d.cb_left = c_q.cb_left - 1'b1;
        if (dwr_valid_i)           c_d.arr_busy = CNT_W'(WRITE_CYC - 1);
        else if (c_q.arr_busy != '0) c_d.arr_busy = c_q.arr_busy - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    rsr_refresh_fifo #(.DEPTH(BUF_DEPTH), .IDX_W(IDX_W)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (act == ACT_COPY),
        .push_idx_i (scan_idx),
        .pop_i      (cb_done),
        .head_o     (head_idx),
        .full_o     (fifo_full),
        .empty_o    (fifo_empty)
    );

    rsr_line_table #(.LINES(LINES), .WAY_W(WAY_W), .AGE_W(AGE_W), .IDX_W(IDX_W)) u_tbl (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .wr_i        (dwr_valid_i),
        .wr_idx_i    (dwr_idx),
        .wr_dirty_i  (dwr_dirty_i),
        .pos_i       (pos_valid_i),
        .pos_idx_i   (pos_idx),
        .pos_rank_i  (pos_rank_i),
        .kill_i      ((act == ACT_WBACK) || (act == ACT_DROP)),
        .kill_idx_i  (scan_idx),
        .queue_i     (act == ACT_COPY),
        .queue_idx_i (scan_idx),
        .done_i      (cb_done),
        .done_idx_i  (head_idx),
        .valid_o     (line_valid),
        .dirty_o     (line_dirty),
        .pend_o      (line_pend),
        .age_o       (line_age),
        .rank_o      (line_rank)
    );

    assign copy_out_o  = (act == ACT_COPY);
    assign wb_req_o    = (act == ACT_WBACK);
    assign inv_o       = (act == ACT_DROP);
    assign act_set_o   = scan_idx[IDX_W-1:WAY_W];
    assign act_way_o   = scan_idx[WAY_W-1:0];
    assign cb_set_o    = head_idx[IDX_W-1:WAY_W];
    assign cb_way_o    = head_idx[WAY_W-1:0];
    assign buf_full_o  = fifo_full;
    assign buf_empty_o = fifo_empty;

    // R3
    one_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({copy_out_o, wb_req_o, inv_o}));
    // R5
    drop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req_o || inv_o) |=> !line_valid[$past(scan_idx)]);
    // R7
    cb_no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        copy_back_o |=> !copy_back_o);
    // R8
    cb_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        copy_back_o |-> !dwr_valid_i);
    // R4
    copy_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        copy_out_o |=> line_pend[$past(scan_idx)] && !buf_empty_o);

endmodule

// File: tb/rsr_ctrl_tb.sv
module rsr_ctrl_tb;
    localparam int SETS = 4, WAYS = 16, AGE_W = 4, EXP = 12, DEPTH = 4, WCYC = 6;
    localparam int LINES = SETS * WAYS;
    localparam int MAXA = (1 << AGE_W) - 1;
    localparam int GAP = 80;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic       tick = 0, dwr_v = 0, dwr_d = 0, pos_v = 0;
    logic [1:0] dwr_set = 0, pos_set = 0;
    logic [3:0] dwr_way = 0, pos_way = 0, pos_rank = 0;
    logic       copy_out, wb_req, inv, copy_back, buf_full, buf_empty;
    logic [1:0] act_set, cb_set;
    logic [3:0] act_way, cb_way;

    rsr_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick),
        .dwr_valid_i(dwr_v), .dwr_set_i(dwr_set), .dwr_way_i(dwr_way), .dwr_dirty_i(dwr_d),
        .pos_valid_i(pos_v), .pos_set_i(pos_set), .pos_way_i(pos_way), .pos_rank_i(pos_rank),
        .copy_out_o(copy_out), .wb_req_o(wb_req), .inv_o(inv),
        .act_set_o(act_set), .act_way_o(act_way),
        .copy_back_o(copy_back), .cb_set_o(cb_set), .cb_way_o(cb_way),
        .buf_full_o(buf_full), .buf_empty_o(buf_empty)
    );

    int checks = 0, errors = 0;
    bit fin = 0;

    // bench model of the line state
    bit mv[LINES], md[LINES], mp[LINES];
    int mage[LINES], mrank[LINES];
    int q[$];
    int cb_rem = 0, abusy = 0, ptr = 0;
    int n_copy = 0, n_wb = 0, n_inv = 0, n_fallback = 0, n_hit = 0, n_cb = 0;

    task automatic chk(string tag, int act_v, int exp_v);
        checks++;
        if (act_v != exp_v) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act_v, exp_v);
        end
    endtask

    function automatic bit is_due(int i);
        return mv[i] && !mp[i] && (mage[i] >= EXP);
    endfunction

    // 0 none, 1 copy-out, 2 write-back, 3 invalidate
    function automatic int exp_kind();
        int didx = {dwr_set, dwr_way};
        if (!is_due(ptr) || (dwr_v && didx == ptr)) return 0;
        if (mrank[ptr] < WAYS / 2 && q.size() < DEPTH) return 1;
        return md[ptr] ? 2 : 3;
    endfunction

    task automatic step();
        int k = exp_kind();
        int got = {copy_out, wb_req, inv};
        int ex = (k == 1) ? 4 : (k == 2) ? 2 : (k == 3) ? 1 : 0;
        bit cbx = (q.size() > 0) && (cb_rem == 0) && (abusy == 0) && !dwr_v;
        int didx = {dwr_set, dwr_way};
        chk("R2 R3 R4 R5 R6 R10 action kind", got, ex);
        if (k != 0) chk("R3 action line", {act_set, act_way}, ptr);
        chk("R7 R8 copy-back start", copy_back, cbx);
        if (cbx) chk("R7 copy-back line order", {cb_set, cb_way}, q[0]);
        chk("R9 full flag", buf_full, q.size() == DEPTH);
        chk("R9 empty flag", buf_empty, q.size() == 0);
        // coverage tallies
        if (k == 1) n_copy++;
        if (k == 2) n_wb++;
        if (k == 3) n_inv++;
        if ((k == 2 || k == 3) && mrank[ptr] < WAYS / 2) n_fallback++;
        if (dwr_v && didx == ptr && is_due(ptr)) n_hit++;
        if (cbx) n_cb++;
        // state update
        for (int i = 0; i < LINES; i++)
            if (tick && mage[i] < MAXA) mage[i]++;
        if (dwr_v) begin
            mage[didx] = 0; mv[didx] = 1; md[didx] = dwr_d;
        end
        if (cb_rem == 1) begin
            mage[q[0]] = 0; mp[q[0]] = 0;
            void'(q.pop_front());
        end
        if (k == 1) begin
            q.push_back(ptr); mp[ptr] = 1;
        end else if (k != 0) begin
            mv[ptr] = 0;
        end
        if (pos_v) mrank[{pos_set, pos_way}] = pos_rank;
        if (cbx) cb_rem = WCYC - 1;
        else if (cb_rem > 0) cb_rem--;
        if (dwr_v) abusy = WCYC - 1;
        else if (abusy > 0) abusy--;
        ptr = (ptr + 1) % LINES;
    endtask

    task automatic cyc();
        @(negedge clk);
        step();
        @(posedge clk);
        #2;
        tick = 0; dwr_v = 0; pos_v = 0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!fin) begin
            errors++;
            $display("FAIL watchdog R7 actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < LINES; i++) begin
            mv[i] = 0; md[i] = 0; mp[i] = 0; mage[i] = 0; mrank[i] = i % WAYS;
        end
        // R1: reset state
        repeat (3) begin
            @(negedge clk);
            chk("R1 reset actions", {copy_out, wb_req, inv, copy_back}, 0);
            chk("R1 reset empty", buf_empty, 1);
            chk("R1 reset full", buf_full, 0);
        end
        @(posedge clk);
        #2 rst_n = 1;
        // R1: first cycle out of reset behaves as reset state
        @(negedge clk);
        chk("R1 post-reset empty", buf_empty, 1);
        step();
        @(posedge clk);
        #2;
        // directed: write every line once, then let all expire together
        for (int i = 0; i < LINES; i++) begin
            dwr_v = 1; {dwr_set, dwr_way} = 6'(i); dwr_d = (i % 3) != 0;
            cyc();
        end
        for (int c = 0; c < 14 * GAP; c++) begin
            tick = (c % GAP) == GAP - 1;
            cyc();
        end
        // random mix with steered writes at expiring scanned lines
        for (int c = 0; c < 18000; c++) begin
            tick = (c % GAP) == GAP - 1;
            if (is_due(ptr) && ($urandom % 4) == 0) begin
                dwr_v = 1; {dwr_set, dwr_way} = 6'(ptr); dwr_d = $urandom % 2;
            end else if (($urandom % 8) == 0) begin
                dwr_v = 1; {dwr_set, dwr_way} = 6'($urandom % LINES); dwr_d = $urandom % 2;
            end
            if (($urandom % 4) == 0) begin
                pos_v = 1; pos_set = 2'($urandom); pos_way = 4'($urandom); pos_rank = 4'($urandom);
            end
            cyc();
        end
        chk("R4 copy-out seen", n_copy > 0, 1);
        chk("R5 write-back seen", n_wb > 0, 1);
        chk("R5 invalidate seen", n_inv > 0, 1);
        chk("R6 full-buffer fallback seen", n_fallback > 0, 1);
        chk("R10 same-cycle write suppression seen", n_hit > 0, 1);
        chk("R7 copy-back seen", n_cb > 0, 1);
        fin = 1;
        summary();
        $finish;
    end

endmodule